// File: doc/BRIEF.md
# Bulk Bitwise Row Operation Sequencer

This block turns a single request for a bulk AND or OR of two memory rows into the ordered series of row commands that makes the memory array compute the result itself. No row data crosses a bus. Rows are moved inside one subarray by issuing two activations back to back. The first activation opens the source row. The second opens the destination row, which overwrites it with the open buffer contents. Three scratch rows are then opened together, and charge sharing leaves every bit at the majority of the three values. When the third scratch row holds a control pattern, the majority gives AND (control all zeros) or OR (control all ones).

A requester presents the operation, two source rows and a destination row with a valid/ready handshake. The sequencer latches them and issues one command per clock on its command port. It holds `busy` for the whole series and pulses `done` once the result has been copied into the destination row. The addresses of the two reserved pattern rows and the three scratch rows are parameters.

Top module: `bbw_sequencer`

## Requirements
- R1: After reset `busy` and `done` are 0, `req_ready` is 1 and `cmd_code` is 0 (no command). Whenever `busy` is 0, `cmd_code` is 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `busy` is 1 for exactly 14 cycles starting the cycle after acceptance, with one command per cycle.
- R3: While `busy` is 1, `req_ready` is 0. Request inputs presented then have no effect on the commands or on the rows written.
- R4: Command codes: 0 none, 1 ACTIVATE, 2 PRECHARGE, 3 triple ACTIVATE. The series for sources A, B, destination C and control row K is: ACT A, ACT S0, PRE, ACT B, ACT S1, PRE, ACT K, ACT S2, PRE, TRIPLE, PRE, ACT S0, ACT C, PRE. S0, S1 and S2 are the scratch rows.
- R5: `req_op` 0 selects AND, where K is the all-zeros row. `req_op` 1 selects OR, where K is the all-ones row.
- R6: Every PRECHARGE and idle cycle drives `cmd_row` to 0. Every copy is ACT source, then ACT destination, then PRE. A triple activation is always followed by PRE.
- R7: A triple activation carries the first scratch row address on `cmd_row`.
- R8: `done` is a one-cycle pulse. It comes in the cycle after the last command, in which `busy` is already 0.
- R9: After `done`, the destination row holds A AND B or A OR B of the source values taken at acceptance. The reserved rows are unchanged. This holds also when A equals B and when C equals A.
- R10: A request presented in the `done` cycle is accepted at once. Its first command follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_op | input | 1 | 0 = AND, 1 = OR |
| req_src_a | input | ROW_W | First source row |
| req_src_b | input | ROW_W | Second source row |
| req_dst | input | ROW_W | Destination row |
| busy | output | 1 | Command series in progress |
| done | output | 1 | One-cycle completion pulse |
| cmd_code | output | 2 | 0 none, 1 ACT, 2 PRE, 3 triple ACT |
| cmd_row | output | ROW_W | Row address for the command |

## Verification
The completion pulse of one request and the acceptance of the next can fall in the same cycle. The bench provokes this by raising `req_valid` with a fresh request in the `done` cycle, for about half of the randomized requests. It then requires that the first command of the new series appears in the very next cycle. Each result is judged in a behavioural row array that applies the majority rule on triple activation. Source values are sampled at acceptance, so a series that starts right after a pulse must still produce the correct destination row. The destination may alias a source.

// File: rtl/bbw_pkg.sv
package bbw_pkg;
  localparam int N_STEPS = 14;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_ACT  = 2'd1,
    CMD_PRE  = 2'd2,
    CMD_TACT = 2'd3
  } bbw_cmd_e;

  typedef enum logic [2:0] {
    SRC_NONE, SRC_A, SRC_B, SRC_C, SRC_CTRL, SRC_S0, SRC_S1, SRC_S2
  } bbw_src_e;

  typedef struct packed {
    bbw_cmd_e kind;
    bbw_src_e src;
  } bbw_step_t;

  function automatic bbw_step_t step_of(input int unsigned idx);
    bbw_step_t s;
    case (idx)
      0:  s = '{CMD_ACT,  SRC_A};
      1:  s = '{CMD_ACT,  SRC_S0};
      3:  s = '{CMD_ACT,  SRC_B};
      4:  s = '{CMD_ACT,  SRC_S1};
      6:  s = '{CMD_ACT,  SRC_CTRL};
      7:  s = '{CMD_ACT,  SRC_S2};
      9:  s = '{CMD_TACT, SRC_S0};
      11: s = '{CMD_ACT,  SRC_S0};
      12: s = '{CMD_ACT,  SRC_C};
      default: s = '{CMD_PRE, SRC_NONE};
    endcase
    return s;
  endfunction
endpackage

// File: rtl/bbw_req_latch.sv
module bbw_req_latch #(
  parameter int ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             op_i,
  input  logic [ROW_W-1:0] a_i,
  input  logic [ROW_W-1:0] b_i,
  input  logic [ROW_W-1:0] c_i,
  output logic             op_o,
  output logic [ROW_W-1:0] a_o,
  output logic [ROW_W-1:0] b_o,
  output logic [ROW_W-1:0] c_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_o <= 1'b0;
      a_o  <= '0;
      b_o  <= '0;
      c_o  <= '0;
    end else if (load) begin
      op_o <= op_i;
      a_o  <= a_i;
      b_o  <= b_i;
      c_o  <= c_i;
    end
  end
endmodule

// File: rtl/bbw_step_ctr.sv
module bbw_step_ctr #(
  parameter int NSTEPS = 14,
  localparam int SW = $clog2(NSTEPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic [SW-1:0] step,
  output logic          last,
  output logic          done
);
  assign last = busy && (step == SW'(NSTEPS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      step <= '0;
      done <= 1'b0;
    end else begin
      done <= last;
      if (start) begin
        busy <= 1'b1;
        step <= '0;
      end else if (busy) begin
        if (last) begin
          busy <= 1'b0;
          step <= '0;
        end else begin
          step <= step + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bbw_row_mux.sv
module bbw_row_mux
  import bbw_pkg::*;
#(
  parameter int ROW_W    = 10,
  parameter int ZERO_ROW = 0,
  parameter int ONE_ROW  = 1,
  parameter int S0_ROW   = 2,
  parameter int S1_ROW   = 3,
  parameter int S2_ROW   = 4
) (
  input  bbw_src_e         sel,
  input  logic             op,
  input  logic [ROW_W-1:0] a,
  input  logic [ROW_W-1:0] b,
  input  logic [ROW_W-1:0] c,
  output logic [ROW_W-1:0] row
);
  logic [ROW_W-1:0] ctrl_row;
  assign ctrl_row = op ? ROW_W'(ONE_ROW) : ROW_W'(ZERO_ROW);

  always_comb begin
    case (sel)
      SRC_A:    row = a;
      SRC_B:    row = b;
      SRC_C:    row = c;
      SRC_CTRL: row = ctrl_row;
      SRC_S0:   row = ROW_W'(S0_ROW);
      SRC_S1:   row = ROW_W'(S1_ROW);
      SRC_S2:   row = ROW_W'(S2_ROW);
      default:  row = '0;
    endcase
  end
endmodule

// File: rtl/bbw_sequencer.sv
module bbw_sequencer
  import bbw_pkg::*;
#(
  parameter int ROW_W    = 10,
  parameter int ZERO_ROW = 0,
  parameter int ONE_ROW  = 1,
  parameter int S0_ROW   = 2,
  parameter int S1_ROW   = 3,
  parameter int S2_ROW   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_op,
  input  logic [ROW_W-1:0] req_src_a,
  input  logic [ROW_W-1:0] req_src_b,
  input  logic [ROW_W-1:0] req_dst,
  output logic             busy,
  output logic             done,
  output logic [1:0]       cmd_code,
  output logic [ROW_W-1:0] cmd_row
);
  localparam int SW = $clog2(N_STEPS);

  logic             accept;
  logic             step_last;
  logic [SW-1:0]    step;
  logic             op_q;
  logic [ROW_W-1:0] a_q, b_q, c_q;
  bbw_step_t        cur;
  bbw_src_e         sel;
  logic [ROW_W-1:0] mux_row;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  bbw_req_latch #(.ROW_W(ROW_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .op_i(req_op), .a_i(req_src_a), .b_i(req_src_b), .c_i(req_dst),
    .op_o(op_q), .a_o(a_q), .b_o(b_q), .c_o(c_q)
  );

  bbw_step_ctr #(.NSTEPS(N_STEPS)) u_ctr (
    .clk(clk), .rst_n(rst_n), .start(accept),
    .busy(busy), .step(step), .last(step_last), .done(done)
  );

  always_comb begin
    cur = step_of(32'(step));
    if (!busy) cur = '{CMD_NONE, SRC_NONE};
  end

  assign sel = cur.src;

  bbw_row_mux #(
    .ROW_W(ROW_W), .ZERO_ROW(ZERO_ROW), .ONE_ROW(ONE_ROW),
    .S0_ROW(S0_ROW), .S1_ROW(S1_ROW), .S2_ROW(S2_ROW)
  ) u_mux (
    .sel(sel), .op(op_q), .a(a_q), .b(b_q), .c(c_q), .row(mux_row)
  );

  assign cmd_code = cur.kind;
  assign cmd_row  = mux_row;
endmodule

// File: rtl/bbw_seq_chk.sv
module bbw_seq_chk #(
  parameter int ROW_W  = 10,
  parameter int S0_ROW = 2,
  parameter int NSTEPS = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             busy,
  input logic             done,
  input logic [1:0]       cmd_code,
  input logic [ROW_W-1:0] cmd_row,
  input logic             accept,
  input logic             last
);
  logic [7:0] run_len;
  always_ff @(posedge clk) begin
    if (!rst_n)      run_len <= '0;
    else if (accept) run_len <= '0;
    else if (busy)   run_len <= run_len + 1'b1;
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cmd_code == 2'd0);
  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);
  p_run_length_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> run_len == 8'(NSTEPS));
  p_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);
  p_pre_after_tact_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_code == 2'd3 |=> cmd_code == 2'd2);
  p_pre_row_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_code == 2'd2 |-> cmd_row == '0);
  p_tact_row_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_code == 2'd3 |-> cmd_row == ROW_W'(S0_ROW));
  p_done_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> done && !busy);
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind bbw_sequencer bbw_seq_chk #(.ROW_W(ROW_W), .S0_ROW(S0_ROW), .NSTEPS(bbw_pkg::N_STEPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .busy(busy), .done(done), .cmd_code(cmd_code), .cmd_row(cmd_row),
  .accept(accept), .last(step_last)
);

// File: tb/bbw_sequencer_test.sv
module bbw_sequencer_test;
  localparam int PERIOD = 10;
  localparam int RW = 10;
  localparam int NROWS = 1 << RW;
  localparam int Z = 0, O = 1, S0 = 2, S1 = 3, S2 = 4;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_op = 0;
  logic [RW-1:0] req_src_a = 0, req_src_b = 0, req_dst = 0;
  logic req_ready, busy, done;
  logic [1:0] cmd_code;
  logic [RW-1:0] cmd_row;

  int n_chk = 0, n_bad = 0;
  logic [63:0] mem [NROWS];
  logic [63:0] rbuf;
  bit row_open = 0;
  int proto_err = 0;

  always #(PERIOD/2) clk = ~clk;

  bbw_sequencer #(.ROW_W(RW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_src_a(req_src_a), .req_src_b(req_src_b), .req_dst(req_dst),
    .busy(busy), .done(done), .cmd_code(cmd_code), .cmd_row(cmd_row)
  );

  // behavioural row array: copies by double activation, majority on triple
  always @(negedge clk) if (rst_n) begin
    case (cmd_code)
      2'd1: begin
        if (!row_open) begin rbuf = mem[cmd_row]; row_open = 1; end
        else mem[cmd_row] = rbuf;
      end
      2'd2: row_open = 0;
      2'd3: begin
        if (row_open) proto_err++;
        rbuf = (mem[S0] & mem[S1]) | (mem[S1] & mem[S2]) | (mem[S0] & mem[S2]);
        mem[S0] = rbuf; mem[S1] = rbuf; mem[S2] = rbuf;
        row_open = 1;
      end
      default: ;
    endcase
  end

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected command k as {code,row}
  function automatic logic [RW+1:0] want(int k, bit op, logic [RW-1:0] a, b, c);
    logic [RW-1:0] k_row = op ? RW'(O) : RW'(Z);
    case (k)
      0: return {2'd1, a};
      1: return {2'd1, RW'(S0)};
      3: return {2'd1, b};
      4: return {2'd1, RW'(S1)};
      6: return {2'd1, k_row};
      7: return {2'd1, RW'(S2)};
      9: return {2'd3, RW'(S0)};
      11: return {2'd1, RW'(S0)};
      12: return {2'd1, c};
      default: return {2'd2, RW'(0)};
    endcase
  endfunction

  function automatic logic [63:0] gold(bit op, logic [63:0] x, y);
    return op ? (x | y) : (x & y);
  endfunction

  // called at a negedge where the sequencer should be ready; returns in the done cycle
  task automatic issue(bit op, logic [RW-1:0] a, b, c, bit stall);
    logic [63:0] va = mem[a], vb = mem[b];
    logic [63:0] z0 = mem[Z], o1 = mem[O];
    bit trace_ok = 1;
    logic [RW+1:0] bad_act = 0, bad_exp = 0;
    chk(req_ready === 1'b1, "R10 ready before request", {63'd0, req_ready}, 64'd1);
    req_op = op; req_src_a = a; req_src_b = b; req_dst = c; req_valid = 1;
    @(negedge clk);
    chk(busy === 1'b1, "R2 busy after accept", {63'd0, busy}, 64'd1);
    for (int k = 0; k < 14; k++) begin
      if (stall) begin
        req_valid = 1; req_op = $urandom; req_src_a = RW'($urandom);
        req_src_b = RW'($urandom); req_dst = RW'($urandom);
      end else req_valid = 0;
      if (k == 5) chk(req_ready === 1'b0 && busy === 1'b1, "R3 ready low while busy",
                      {62'd0, busy, req_ready}, 64'd2);
      if ({cmd_code, cmd_row} !== want(k, op, a, b, c) && trace_ok) begin
        trace_ok = 0; bad_act = {cmd_code, cmd_row}; bad_exp = want(k, op, a, b, c);
      end
      @(negedge clk);
    end
    req_valid = 0;
    chk(trace_ok, op ? "R5 OR command series" : "R4 AND command series",
        64'(bad_act), 64'(bad_exp));
    chk(done === 1'b1 && busy === 1'b0, "R8 done pulse after last command",
        {62'd0, done, busy}, 64'd2);
    chk(mem[c] === gold(op, va, vb), "R9 destination row", mem[c], gold(op, va, vb));
    chk(mem[Z] === z0 && mem[O] === o1, "R9 reserved rows intact", mem[Z] ^ z0, 64'd0);
  endtask

  initial begin
    #(PERIOD * 100000);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int r = 0; r < NROWS; r++) mem[r] = {$urandom, $urandom};
    mem[Z] = '0; mem[O] = '1;
    repeat (3) @(negedge clk);
    chk(busy === 0 && done === 0 && req_ready === 1 && cmd_code === 0,
        "R1 reset state", {60'd0, busy, done, req_ready, 1'b0}, 64'd2);
    rst_n = 1;
    @(negedge clk);
    chk(cmd_code === 2'd0, "R1 idle no command", 64'(cmd_code), 64'd0);
    // directed corners
    mem[10] = 64'hF0F0_1234_FFFF_0000; mem[11] = 64'hFF00_4321_0F0F_8001;
    issue(0, 10, 11, 12, 0);
    @(negedge clk);
    chk(done === 1'b0, "R8 done lasts one cycle", 64'(done), 64'd0);
    issue(1, 10, 11, 13, 1);
    @(negedge clk);
    issue(0, 20, 20, 21, 0);   // A equals B
    issue(1, 22, 23, 22, 0);   // C equals A, back-to-back
    @(negedge clk);
    chk(cmd_code === 2'd0 && busy === 1'b0, "R1 quiet after finish", 64'(cmd_code), 64'd0);
    // randomized requests, half back-to-back
    for (int i = 0; i < 24; i++) begin
      logic [RW-1:0] a = RW'(5 + $urandom_range(NROWS - 6));
      logic [RW-1:0] b = RW'(5 + $urandom_range(NROWS - 6));
      logic [RW-1:0] c = RW'(5 + $urandom_range(NROWS - 6));
      issue(1'($urandom), a, b, c, 1'($urandom));
      if ($urandom_range(1) == 0) @(negedge clk);
    end
    @(negedge clk);
    chk(proto_err == 0, "R6 triple activation on closed bank", 64'(proto_err), 64'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule